// File: doc/BRIEF.md
# Clear-on-Read Interrupt Collector with Configurable Pin

This block gathers single-cycle event pulses from the rest of the chip into sticky status bits. Each status bit has its own mask bit. The block drives one interrupt pin from the OR of all status bits whose mask is open. Software reads a status register to learn which events occurred, and that read clears the register. The interrupt therefore drops once every pending, unmasked bit has been read away.

A small configuration register sets how the pin behaves at the board level. The pin can be active-high or active-low. It can be driven at all times (push-pull), or driven only while asserted and left floating otherwise, so that several such pins can share one wire as a wired-OR or wired-AND net. The pin is delivered as a data value plus an output-enable. The pad driver sits outside this block.

Registers are reached through a simple synchronous port with an address, write data, a write strobe and a read strobe. Read data is registered and appears on the cycle after the strobe.

Top module: `irq_cor_top`

## Requirements
- R1: After reset, every status bit reads 0, every mask bit reads 1 (masked), the configuration register reads 0, and the pin outputs are irq_o = 0 with irq_oe_o = 1.
- R2: An event pulse on evt_i bit k*8+b sets bit b of status register k. Status register k is at address k, so status 0 is at address 0 and status 1 is at address 1. The bit stays set until it is cleared by a read.
- R3: The interrupt is active when any status bit is set and its mask bit is 0. The pin shows this one clock after the status bit changes.
- R4: A read strobe to a status register returns its value on rdata_o one cycle later and clears that register. The other status register is left unchanged.
- R5: An event that arrives in the same cycle as a read-clear of its status bit leaves that bit set after the read.
- R6: A masked event is still latched into its status bit but does not activate the interrupt. Clearing the mask bit (writing 0) of a pending bit activates the interrupt.
- R7: Mask register k is at address 2+k and is read/write. The configuration register is at address 4. In the configuration register, bit 4 set makes the active level 0 and the idle level 1. All other configuration bits read as 0.
- R8: When configuration bit 6 is set, the pin is in wired mode. irq_oe_o is 1 only while the interrupt is active, and irq_o always carries the active level.
- R9: Writes to status registers and to unmapped addresses (5 to 7) have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Event pulses, bit k*8+b feeds status k bit b |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a read of a status register clears it |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe_o | output | 1 | Interrupt pin output-enable |

## Verification
Assertions check the status latching on every cycle. Each event sets its bit. No bit falls without a read-clear. A read-clear with no coinciding event empties the register. In the pin driver, the assertions check that push-pull mode always enables the output and that wired mode always presents the active level. Some behaviours can only be shown by the bench's scenarios: the register address map, clearing one register while the other is left alone, unmasking a bit that is already pending, inversion combined with wired mode, and writes to read-only or unmapped addresses being ignored.

// File: rtl/irq_cor_pkg.sv
package irq_cor_pkg;

   // Decoded pin behaviour taken from the configuration register
   typedef struct packed {
      logic inv;    // active level is 0 when set
      logic wired;  // drive only while active
   } pin_cfg_t;

   // Data value on the pin for a given activity and configuration
   function automatic logic pin_level(input logic act, input pin_cfg_t cfg);
      if (cfg.wired)
         return ~cfg.inv;
      return act ^ cfg.inv;
   endfunction

   // Output enable for a given activity and configuration
   function automatic logic pin_enable(input logic act, input pin_cfg_t cfg);
      return cfg.wired ? act : 1'b1;
   endfunction

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] evt_i,
   input  logic             rd_clr_i,
   output logic [REG_W-1:0] status_o
);

   if (REG_W < 1) begin : g_bad_width
      $error("irq_stat_bank: REG_W must be at least 1");
   end

   logic [REG_W-1:0] status_q;
   logic [REG_W-1:0] keep;

   always_comb begin
      keep = rd_clr_i ? '0 : status_q;
   end

   // new events win over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= keep | evt_i;
   end

   assign status_o = status_q;

   // R2 R5
   evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(evt_i)) == $past(evt_i)));

   // R2
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R4
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && (evt_i == '0)) |=> (status_q == '0));

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
   import irq_cor_pkg::*;
#(
   parameter bit PIN_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     act_i,
   input  pin_cfg_t cfg_i,
   output logic     irq_o,
   output logic     irq_oe_o
);

   if (PIN_REG) begin : g_flop
      logic lvl_q;
      logic oe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b0;
            oe_q  <= 1'b1;
         end else begin
            lvl_q <= pin_level(act_i, cfg_i);
            oe_q  <= pin_enable(act_i, cfg_i);
         end
      end

      assign irq_o    = lvl_q;
      assign irq_oe_o = oe_q;

      // R3 R7
      push_pull_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(cfg_i.wired) |-> irq_oe_o);

      // R8
      wired_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(cfg_i.wired) |-> (irq_o == !$past(cfg_i.inv)));

      // R3
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(act_i) && !$past(cfg_i.wired)) |-> (irq_o == $past(cfg_i.inv)));
   end else begin : g_comb
      assign irq_o    = pin_level(act_i, cfg_i);
      assign irq_oe_o = pin_enable(act_i, cfg_i);
   end

endmodule

// File: rtl/irq_cor_top.sv
module irq_cor_top
   import irq_cor_pkg::*;
#(
   parameter int NUM_REGS  = 2,
   parameter int REG_W     = 8,
   parameter int ADDR_W    = 3,
   parameter int INV_BIT   = 4,
   parameter int WIRED_BIT = 6,
   parameter bit PIN_REG   = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REGS*REG_W-1:0] evt_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [REG_W-1:0]          wdata_i,
   input  logic                      wr_i,
   input  logic                      rd_i,
   output logic [REG_W-1:0]          rdata_o,
   output logic                      irq_o,
   output logic                      irq_oe_o
);

   localparam int MASK_BASE = NUM_REGS;
   localparam int CFG_ADDR  = 2 * NUM_REGS;

   if (CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_cor_top: ADDR_W too small for the register map");
   end
   if (INV_BIT >= REG_W || WIRED_BIT >= REG_W || INV_BIT == WIRED_BIT) begin : g_bad_cfg
      $error("irq_cor_top: configuration bit positions invalid");
   end

   logic [NUM_REGS-1:0][REG_W-1:0] status_w;
   logic [NUM_REGS-1:0][REG_W-1:0] mask_q;
   logic [NUM_REGS-1:0]            pend;
   pin_cfg_t                       cfg_q;
   logic [REG_W-1:0]               rd_mux;
   logic [REG_W-1:0]               rdata_q;
   logic                           cfg_wr;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic rd_clr;
      logic mask_wr;

      assign rd_clr  = rd_i && (addr_i == ADDR_W'(k));
      assign mask_wr = wr_i && (addr_i == ADDR_W'(MASK_BASE + k));

      irq_stat_bank #(.REG_W(REG_W)) stat_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt_i[k*REG_W +: REG_W]),
         .rd_clr_i (rd_clr),
         .status_o (status_w[k])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[k] <= '1;
         else if (mask_wr)
            mask_q[k] <= wdata_i;
      end

      assign pend[k] = |(status_w[k] & ~mask_q[k]);
   end

   assign cfg_wr = wr_i && (addr_i == ADDR_W'(CFG_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (cfg_wr) begin
         cfg_q.inv   <= wdata_i[INV_BIT];
         cfg_q.wired <= wdata_i[WIRED_BIT];
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (addr_i == ADDR_W'(k))
            rd_mux = status_w[k];
         if (addr_i == ADDR_W'(MASK_BASE + k))
            rd_mux = mask_q[k];
      end
      if (addr_i == ADDR_W'(CFG_ADDR)) begin
         rd_mux[INV_BIT]   = cfg_q.inv;
         rd_mux[WIRED_BIT] = cfg_q.wired;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_i)
         rdata_q <= rd_mux;
   end

   assign rdata_o = rdata_q;

   irq_pin_drv #(.PIN_REG(PIN_REG)) pin_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (|pend),
      .cfg_i    (cfg_q),
      .irq_o    (irq_o),
      .irq_oe_o (irq_oe_o)
   );

endmodule

// File: tb/irq_cor_top_tb_top.sv
module irq_cor_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt = '0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  rdata;
   logic        irq;
   logic        irq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   always #5 clk = ~clk;

   irq_cor_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt),
      .addr_i   (addr),
      .wdata_i  (wdata),
      .wr_i     (wr),
      .rd_i     (rd),
      .rdata_o  (rdata),
      .irq_o    (irq),
      .irq_oe_o (irq_oe)
   );

   // monitor: a strobe seen at a falling edge was taken at the rising edge before
   always @(negedge clk) begin
      if (rd) begin
         exp_t e;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL read with empty scoreboard actual=%h expected=none", rdata);
         end else begin
            e = exp_q.pop_front();
            if (rdata !== e.val) begin
               errors++;
               $display("FAIL %s read actual=%h expected=%h", e.tag, rdata, e.val);
            end
         end
      end
   end

   task automatic do_read(input logic [2:0] a, input logic [7:0] v, input string tag,
                          input logic [15:0] ev = '0);
      @(negedge clk); #1;
      rd = 1'b1; addr = a; evt = ev;
      exp_q.push_back('{val: v, tag: tag});
      @(negedge clk); #1;
      rd = 1'b0; evt = '0;
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk); #1;
      wr = 1'b1; addr = a; wdata = v;
      @(negedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] ev);
      @(negedge clk); #1;
      evt = ev;
      @(negedge clk); #1;
      evt = '0;
   endtask

   // waits for the pin register, then compares at the falling edge
   task automatic check_pin(input logic exp_d, input logic exp_oe, input string tag);
      @(negedge clk);
      checks++;
      if (irq !== exp_d || irq_oe !== exp_oe) begin
         errors++;
         $display("FAIL %s pin actual=%b/%b expected=%b/%b", tag, irq, irq_oe, exp_d, exp_oe);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      checks++;
      if (irq !== 1'b0 || irq_oe !== 1'b1) begin
         errors++;
         $display("FAIL R1 pin actual=%b/%b expected=0/1", irq, irq_oe);
      end
      do_read(3'd0, 8'h00, "R1 status0");
      do_read(3'd2, 8'hFF, "R1 mask0");
      do_read(3'd3, 8'hFF, "R1 mask1");
      do_read(3'd4, 8'h00, "R1 config");

      // R6 masked event latched, no interrupt
      pulse(16'h0008);
      check_pin(1'b0, 1'b1, "R6 masked");
      do_read(3'd0, 8'h08, "R2 status0 bit3");
      do_read(3'd0, 8'h00, "R4 status0 cleared");

      // R3 unmasked event raises pin
      do_write(3'd2, 8'hF7);
      do_read(3'd2, 8'hF7, "R7 mask0 readback");
      pulse(16'h0008);
      check_pin(1'b1, 1'b1, "R3 assert");
      do_read(3'd1, 8'h00, "R4 other register");
      check_pin(1'b1, 1'b1, "R4 still pending");
      do_read(3'd0, 8'h08, "R4 status0 value");
      check_pin(1'b0, 1'b1, "R4 pin drops");

      // R5 event during read-clear survives
      pulse(16'h0008);
      do_read(3'd0, 8'h08, "R5 first read", 16'h0008);
      do_read(3'd0, 8'h08, "R5 bit kept");
      do_read(3'd0, 8'h00, "R5 then cleared");

      // R6 unmasking a pending bit
      pulse(16'h0100);
      check_pin(1'b0, 1'b1, "R6 masked reg1");
      do_write(3'd3, 8'hFE);
      check_pin(1'b1, 1'b1, "R6 unmask pending");
      do_read(3'd1, 8'h01, "R2 status1 bit0");
      check_pin(1'b0, 1'b1, "R4 reg1 clear");

      // R7 inverted push-pull
      do_write(3'd4, 8'h10);
      check_pin(1'b1, 1'b1, "R7 idle high");
      pulse(16'h0008);
      check_pin(1'b0, 1'b1, "R7 active low");
      do_read(3'd0, 8'h08, "R7 clear");
      check_pin(1'b1, 1'b1, "R7 idle again");

      // R8 wired mode, both polarities
      do_write(3'd4, 8'h40);
      check_pin(1'b1, 1'b0, "R8 wired idle");
      pulse(16'h0008);
      check_pin(1'b1, 1'b1, "R8 wired active");
      do_read(3'd0, 8'h08, "R8 clear");
      check_pin(1'b1, 1'b0, "R8 released");
      do_write(3'd4, 8'hFF);
      do_read(3'd4, 8'h50, "R7 config bits only");
      pulse(16'h0008);
      check_pin(1'b0, 1'b1, "R8 wired active low");
      do_read(3'd0, 8'h08, "R8 clear low");
      check_pin(1'b0, 1'b0, "R8 released low");

      // R9 ignored writes and unmapped reads
      do_write(3'd0, 8'hFF);
      do_read(3'd0, 8'h00, "R9 status not writable");
      check_pin(1'b0, 1'b0, "R9 pin unchanged");
      do_write(3'd6, 8'h55);
      do_read(3'd6, 8'h00, "R9 unmapped 6");
      do_read(3'd5, 8'h00, "R9 unmapped 5");
      do_read(3'd2, 8'hF7, "R9 mask0 untouched");
      do_read(3'd4, 8'h50, "R9 config untouched");

      @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      finish_run();
   end

endmodule